// File: doc/BRIEF.md
# Chain Node Distribute-and-Gather Sequencer

This block sequences the channel traffic of one node in a linear chain of processing nodes. The chain shares a block of data and gathers results back to the source. The node has two blocking channels. The source-side channel (upstream) lies toward the data source. The far-side channel (downstream) leads to the nodes further along the chain. A static position input tells the node how many nodes lie beyond it. A static packet-length input gives the number of words each node processes.

Every round has four phases:

- The node passes on all words meant for nodes further along.
- It reads its own packet and streams that packet into an external compute hook over a valid/ready handshake.
- It takes the hook's single result word. Unless it is the last node, it adds the partial result fetched from downstream.
- It writes one word back upstream.

Rounds repeat without end. Each channel access is a request held until the channel pulses done. Only one access is ever open at a time.

Top module: `gather_node_seq`

## Requirements
- R1: Each round begins with pos·len upstream reads. Each word read is written downstream, unchanged and in arrival order, before the next upstream read.
- R2: After forwarding, exactly len further upstream words are read. They are presented to the compute hook in arrival order and never written downstream.
- R3: A node with pos ≠ 0 reads exactly one downstream word per round, after the hook result. A node with pos = 0 never requests a downstream read.
- R4: Each round ends with exactly one upstream write. Its value is the hook result plus the downstream word when pos ≠ 0. It is the hook result alone when pos = 0. The sum is taken modulo 2^DATA_W.
- R5: When pos·len = 0, the forwarding phase is skipped. When len = 0, no words go to the hook, but the hook result is still taken and the round still completes.
- R6: A request stays asserted until its done is seen. Write data stays stable while a write waits.
- R7: At most one of the six request/valid/ready outputs toward channels and hook is high in any cycle.
- R8: Rounds follow one another indefinitely. Upstream read data in round r continues the word stream where round r−1 stopped.
- R9: While reset is asserted, all request, valid and ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nodePos | input | POS_W | Number of nodes beyond this one (static) |
| pktLen | input | LEN_W | Words per node packet (static) |
| upRdReq | output | 1 | Upstream read request |
| upRdDone | input | 1 | Upstream read completes this cycle |
| upRdData | input | DATA_W | Upstream read word |
| upWrReq | output | 1 | Upstream write request |
| upWrData | output | DATA_W | Result word written upstream |
| upWrDone | input | 1 | Upstream write completes this cycle |
| dnWrReq | output | 1 | Downstream write request |
| dnWrData | output | DATA_W | Forwarded word |
| dnWrDone | input | 1 | Downstream write completes this cycle |
| dnRdReq | output | 1 | Downstream read request |
| dnRdDone | input | 1 | Downstream read completes this cycle |
| dnRdData | input | DATA_W | Downstream partial result |
| hookValid | output | 1 | Local word valid toward compute hook |
| hookData | output | DATA_W | Local word |
| hookReady | input | 1 | Hook accepts local word |
| hookResReady | output | 1 | Sequencer waits for the hook result |
| hookResValid | input | 1 | Hook result valid |
| hookResData | input | DATA_W | Hook result word |

## Verification
The bench stresses the boundaries between phases:

- **Last node (pos = 0).** Here a design that always fetches a partial result would hang waiting for a downstream read.
- **pos·len = 0.** A counter compared after incrementing would wrap and forward thousands of stray words.
- **len = 0.** A design that demands at least one local word would stall before the result.

Stalled done and ready responses check that requests are held and that write data stays put. Several rounds per scenario check that the word stream continues across rounds. A design that loses a word at a round boundary would shift every later forwarded word and result.

// File: rtl/gns_pkg.sv
package gns_pkg;

  typedef enum logic [2:0] {
    S_START,
    S_FWD_RD,
    S_FWD_WR,
    S_LOC_RD,
    S_LOC_PUSH,
    S_RES,
    S_DN_RD,
    S_UP_WR
  } seqState_t;

  typedef struct packed {
    logic loadHold;
    logic clrCnt;
    logic incCnt;
    logic loadAcc;
    logic addAcc;
  } dpCtl_t;

endpackage

// File: rtl/gns_dpath.sv
module gns_dpath
  import gns_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int POS_W  = 4,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [POS_W-1:0]  nodePos,
  input  logic [LEN_W-1:0]  pktLen,
  input  logic [DATA_W-1:0] upRdData,
  input  logic [DATA_W-1:0] dnRdData,
  input  logic [DATA_W-1:0] hookResData,
  output logic [DATA_W-1:0] holdWord,
  output logic [DATA_W-1:0] accWord,
  output logic              fwdEmpty,
  output logic              locEmpty,
  output logic              fwdLast,
  output logic              locLast
);
  localparam int CNT_W = POS_W + LEN_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] fwdTotal;
  logic [CNT_W-1:0] locTotal;

  assign fwdTotal = CNT_W'(nodePos) * CNT_W'(pktLen);
  assign locTotal = CNT_W'(pktLen);
  assign cntNext  = cnt + CNT_W'(1);
  assign fwdEmpty = (fwdTotal == '0);
  assign locEmpty = (locTotal == '0);
  assign fwdLast  = (cntNext == fwdTotal);
  assign locLast  = (cntNext == locTotal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      holdWord <= '0;
      accWord  <= '0;
    end else begin
      if (ctl.clrCnt)      cnt <= '0;
      else if (ctl.incCnt) cnt <= cntNext;
      if (ctl.loadHold) holdWord <= upRdData;
      if (ctl.loadAcc)      accWord <= hookResData;
      else if (ctl.addAcc)  accWord <= accWord + dnRdData;
    end
  end

  // R2: count never runs past the local packet while pushing local words
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.incCnt && !ctl.clrCnt |-> (cntNext <= fwdTotal) || (cntNext <= locTotal));

endmodule

// File: rtl/gns_ctrl.sv
module gns_ctrl
  import gns_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   nodeIsLast,
  input  logic   fwdEmpty,
  input  logic   locEmpty,
  input  logic   fwdLast,
  input  logic   locLast,
  input  logic   upRdDone,
  input  logic   upWrDone,
  input  logic   dnWrDone,
  input  logic   dnRdDone,
  input  logic   hookReady,
  input  logic   hookResValid,
  output logic   upRdReq,
  output logic   upWrReq,
  output logic   dnWrReq,
  output logic   dnRdReq,
  output logic   hookValid,
  output logic   hookResReady,
  output dpCtl_t ctl
);
  seqState_t st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_START;
    else       st <= nxt;
  end

  always_comb begin
    nxt = st;
    ctl = '0;
    case (st)
      S_START: begin
        ctl.clrCnt = 1'b1;
        if (!fwdEmpty)      nxt = S_FWD_RD;
        else if (!locEmpty) nxt = S_LOC_RD;
        else                nxt = S_RES;
      end
      S_FWD_RD: if (upRdDone) begin
        ctl.loadHold = 1'b1;
        nxt = S_FWD_WR;
      end
      S_FWD_WR: if (dnWrDone) begin
        if (fwdLast) begin
          ctl.clrCnt = 1'b1;
          nxt = locEmpty ? S_RES : S_LOC_RD;
        end else begin
          ctl.incCnt = 1'b1;
          nxt = S_FWD_RD;
        end
      end
      S_LOC_RD: if (upRdDone) begin
        ctl.loadHold = 1'b1;
        nxt = S_LOC_PUSH;
      end
      S_LOC_PUSH: if (hookReady) begin
        if (locLast) nxt = S_RES;
        else begin
          ctl.incCnt = 1'b1;
          nxt = S_LOC_RD;
        end
      end
      S_RES: if (hookResValid) begin
        ctl.loadAcc = 1'b1;
        nxt = nodeIsLast ? S_UP_WR : S_DN_RD;
      end
      S_DN_RD: if (dnRdDone) begin
        ctl.addAcc = 1'b1;
        nxt = S_UP_WR;
      end
      S_UP_WR: if (upWrDone) nxt = S_START;
      default: nxt = S_START;
    endcase
  end

  assign upRdReq      = (st == S_FWD_RD) || (st == S_LOC_RD);
  assign dnWrReq      = (st == S_FWD_WR);
  assign hookValid    = (st == S_LOC_PUSH);
  assign hookResReady = (st == S_RES);
  assign dnRdReq      = (st == S_DN_RD);
  assign upWrReq      = (st == S_UP_WR);

  p_one_access_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones({upRdReq, upWrReq, dnWrReq, dnRdReq, hookValid, hookResReady}) <= 1);

  p_hold_uprd_r6: assert property (@(posedge clk) disable iff (!rstN)
    upRdReq && !upRdDone |=> upRdReq);

  p_hold_upwr_r6: assert property (@(posedge clk) disable iff (!rstN)
    upWrReq && !upWrDone |=> upWrReq);

  p_no_dn_fetch_r3: assert property (@(posedge clk) disable iff (!rstN)
    nodeIsLast |-> !dnRdReq);

endmodule

// File: rtl/gather_node_seq.sv
module gather_node_seq
  import gns_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int POS_W  = 4,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [POS_W-1:0]  nodePos,
  input  logic [LEN_W-1:0]  pktLen,
  output logic              upRdReq,
  input  logic              upRdDone,
  input  logic [DATA_W-1:0] upRdData,
  output logic              upWrReq,
  output logic [DATA_W-1:0] upWrData,
  input  logic              upWrDone,
  output logic              dnWrReq,
  output logic [DATA_W-1:0] dnWrData,
  input  logic              dnWrDone,
  output logic              dnRdReq,
  input  logic              dnRdDone,
  input  logic [DATA_W-1:0] dnRdData,
  output logic              hookValid,
  output logic [DATA_W-1:0] hookData,
  input  logic              hookReady,
  output logic              hookResReady,
  input  logic              hookResValid,
  input  logic [DATA_W-1:0] hookResData
);
  dpCtl_t            ctl;
  logic              fwdEmpty, locEmpty, fwdLast, locLast;
  logic [DATA_W-1:0] holdWord, accWord;
  logic              nodeIsLast;

  assign nodeIsLast = (nodePos == '0);

  gns_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .nodeIsLast(nodeIsLast),
    .fwdEmpty(fwdEmpty), .locEmpty(locEmpty), .fwdLast(fwdLast), .locLast(locLast),
    .upRdDone(upRdDone), .upWrDone(upWrDone), .dnWrDone(dnWrDone), .dnRdDone(dnRdDone),
    .hookReady(hookReady), .hookResValid(hookResValid),
    .upRdReq(upRdReq), .upWrReq(upWrReq), .dnWrReq(dnWrReq), .dnRdReq(dnRdReq),
    .hookValid(hookValid), .hookResReady(hookResReady), .ctl(ctl)
  );

  gns_dpath #(.DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .nodePos(nodePos), .pktLen(pktLen),
    .upRdData(upRdData), .dnRdData(dnRdData), .hookResData(hookResData),
    .holdWord(holdWord), .accWord(accWord),
    .fwdEmpty(fwdEmpty), .locEmpty(locEmpty), .fwdLast(fwdLast), .locLast(locLast)
  );

  assign dnWrData = holdWord;
  assign hookData = holdWord;
  assign upWrData = accWord;

  // R1: forwarded word equals the word just read upstream
  p_fwd_match_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dnWrReq) |-> dnWrData == $past(upRdData));

  p_dnwr_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    dnWrReq && !dnWrDone |=> $stable(dnWrData));

  // R4: a non-last node only writes upstream right after its downstream fetch
  p_sum_path_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(upWrReq) && !nodeIsLast |-> $past(dnRdReq && dnRdDone));

  p_last_result_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(upWrReq) && nodeIsLast |-> upWrData == $past(hookResData));

endmodule

// File: tb/gather_node_seq_test.sv
`timescale 1ns/1ps
module gather_node_seq_test;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] nodePos = '0;
  logic [5:0] pktLen = '0;
  logic upRdReq, upWrReq, dnWrReq, dnRdReq, hookValid, hookResReady;
  logic upRdDone = 0, upWrDone = 0, dnWrDone = 0, dnRdDone = 0;
  logic hookReady = 0, hookResValid = 0;
  logic [DW-1:0] upRdData = '0, dnRdData = '0, hookResData = '0;
  logic [DW-1:0] upWrData, dnWrData, hookData;

  always #4 clk = ~clk;

  gather_node_seq uut (
    .clk(clk), .rstN(rstN), .nodePos(nodePos), .pktLen(pktLen),
    .upRdReq(upRdReq), .upRdDone(upRdDone), .upRdData(upRdData),
    .upWrReq(upWrReq), .upWrData(upWrData), .upWrDone(upWrDone),
    .dnWrReq(dnWrReq), .dnWrData(dnWrData), .dnWrDone(dnWrDone),
    .dnRdReq(dnRdReq), .dnRdDone(dnRdDone), .dnRdData(dnRdData),
    .hookValid(hookValid), .hookData(hookData), .hookReady(hookReady),
    .hookResReady(hookResReady), .hookResValid(hookResValid), .hookResData(hookResData)
  );

  int compared = 0;
  int mismatched = 0;
  int upRdCnt, upWrCnt, dnWrCnt, dnRdCnt, hookCnt, multiCnt, target;
  bit halt, stallOn;
  logic [15:0] lfsr = 16'hACE1;
  logic [DW-1:0] srcBase, hookSum;
  logic [DW-1:0] fwdLog [0:511];
  logic [DW-1:0] hookLog [0:255];
  logic [DW-1:0] upWrLog [0:15];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic bit grant(input int b);
    return !stallOn || lfsr[b];
  endfunction

  // one negedge of channel and hook responders
  task automatic service();
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if ($countones({upRdReq, upWrReq, dnWrReq, dnRdReq, hookValid, hookResReady}) > 1)
      multiCnt++;
    if (upRdDone) upRdDone = 0;
    else if (upRdReq && !halt && grant(0)) begin
      upRdData = srcBase + DW'(upRdCnt); upRdCnt++; upRdDone = 1;
    end
    if (dnWrDone) dnWrDone = 0;
    else if (dnWrReq && !halt && grant(3)) begin
      if (dnWrCnt < 512) fwdLog[dnWrCnt] = dnWrData;
      dnWrCnt++; dnWrDone = 1;
    end
    if (hookReady) hookReady = 0;
    else if (hookValid && !halt && grant(5)) begin
      if (hookCnt < 256) hookLog[hookCnt] = hookData;
      hookSum = hookSum + hookData; hookCnt++; hookReady = 1;
    end
    if (hookResValid) hookResValid = 0;
    else if (hookResReady && !halt && grant(7)) begin
      hookResData = hookSum + 16'h0100; hookSum = '0; hookResValid = 1;
    end
    if (dnRdDone) dnRdDone = 0;
    else if (dnRdReq && !halt && grant(9)) begin
      dnRdData = 16'h0A00 + DW'(upWrCnt); dnRdCnt++; dnRdDone = 1;
    end
    if (upWrDone) upWrDone = 0;
    else if (upWrReq && !halt && grant(11)) begin
      if (upWrCnt < 16) upWrLog[upWrCnt] = upWrData;
      upWrCnt++; upWrDone = 1;
      if (upWrCnt == target) halt = 1;
    end
  endtask

  task automatic run_scenario(input int n, input int m, input int rounds, input bit stall,
                              input logic [DW-1:0] base, input string name);
    int fwdBad, hookBad;
    logic [DW-1:0] sum, exp;
    @(negedge clk);
    rstN = 0; nodePos = 4'(n); pktLen = 6'(m);
    upRdDone = 0; upWrDone = 0; dnWrDone = 0; dnRdDone = 0; hookReady = 0; hookResValid = 0;
    upRdCnt = 0; upWrCnt = 0; dnWrCnt = 0; dnRdCnt = 0; hookCnt = 0; multiCnt = 0;
    halt = 0; stallOn = stall; srcBase = base; hookSum = '0; target = rounds;
    repeat (2) @(negedge clk);
    rstN = 1;
    for (int c = 0; c < 20000 && !halt; c++) service();
    check(halt, {name, " R8 rounds completed"}, upWrCnt, rounds);
    repeat (20) service();
    // R1: forwarded stream
    check(dnWrCnt == rounds * n * m, {name, " R1 forwarded count"}, dnWrCnt, rounds * n * m);
    fwdBad = 0;
    for (int r = 0; r < rounds; r++)
      for (int i = 0; i < n * m; i++)
        if (fwdLog[r*n*m+i] !== base + DW'(r*(n+1)*m + i)) fwdBad++;
    check(fwdBad == 0, {name, " R1/R6 forwarded words in order"}, fwdBad, 0);
    // R2/R5: local stream
    check(hookCnt == rounds * m, {name, " R2/R5 local word count"}, hookCnt, rounds * m);
    check(upRdCnt == rounds * (n+1) * m, {name, " R2 upstream read count"}, upRdCnt, rounds * (n+1) * m);
    hookBad = 0;
    for (int r = 0; r < rounds; r++)
      for (int j = 0; j < m; j++)
        if (hookLog[r*m+j] !== base + DW'(r*(n+1)*m + n*m + j)) hookBad++;
    check(hookBad == 0, {name, " R2 local words in order"}, hookBad, 0);
    // R3
    check(dnRdCnt == (n != 0 ? rounds : 0), {name, " R3 downstream reads"}, dnRdCnt, (n != 0 ? rounds : 0));
    // R4/R8
    check(upWrCnt == rounds, {name, " R4 one upstream write per round"}, upWrCnt, rounds);
    for (int r = 0; r < rounds; r++) begin
      sum = '0;
      for (int j = 0; j < m; j++) sum = sum + base + DW'(r*(n+1)*m + n*m + j);
      exp = sum + 16'h0100 + ((n != 0) ? 16'h0A00 + DW'(r) : 16'h0);
      check(upWrLog[r] === exp, {name, $sformatf(" R4/R8 result round %0d", r)}, int'(upWrLog[r]), int'(exp));
    end
    check(multiCnt == 0, {name, " R7 single access"}, multiCnt, 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    rstN = 0; nodePos = 4'd4; pktLen = 6'd16;
    repeat (3) @(negedge clk);
    check({upRdReq, upWrReq, dnWrReq, dnRdReq, hookValid, hookResReady} == 6'b0,
          "R9 outputs idle in reset",
          int'({upRdReq, upWrReq, dnWrReq, dnRdReq, hookValid, hookResReady}), 0);
  endtask

  initial begin
    test_reset();
    run_scenario(4, 16, 2, 1'b0, 16'h1000, "first node");
    run_scenario(0, 5, 3, 1'b0, 16'h2000, "last node");
    run_scenario(3, 0, 2, 1'b0, 16'h3000, "empty packet");
    run_scenario(2, 3, 3, 1'b1, 16'hFFF0, "stalled");
    run_scenario(0, 0, 2, 1'b1, 16'h0040, "no data");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule